// File: doc/BRIEF.md
# Saturating double-and-accumulate unit

This unit performs signed 32-bit double-and-add and double-and-subtract. When a strobe marks the inputs valid, it doubles the second operand and clamps that to the signed 32-bit range. It then adds the clamped value to the first operand, or subtracts it from the first operand, and clamps the outcome a second time. The result is registered and appears one clock later with a valid strobe.

Along with the result, the unit gives a one-cycle saturation pulse that reports whether either clamping stage took effect. It also keeps a sticky status bit that records every saturation since the bit was last cleared. A dedicated synchronous input clears the sticky bit.

The two-stage clamping is visible at the outputs. With A = -1 and B = 0x4000_0000, the unit returns 0x7FFF_FFFE, not the 0x7FFF_FFFF that a single wide clamp would give.

Top module: `sat_dbl_acc`

## Requirements
- R1: While rst is high, on each clock the result output goes to 0 and valid_out, sat_out and q_flag go to 0.
- R2: valid_out is high in the cycle after each cycle with valid_in high, and low otherwise. The result output changes only in the cycle after an accepted operation and holds its value through idle cycles.
- R3: With op_sub = 0, the result is sat(A + sat(2*B)), where sat() clamps to the signed 32-bit range.
- R4: With op_sub = 1, the result is sat(A - sat(2*B)).
- R5: The doubled operand is clamped before it is combined with A. It becomes 0x7FFF_FFFF when 2*B > 2^31-1 and 0x8000_0000 when 2*B < -2^31. B = 0x8000_0000 therefore doubles to 0x8000_0000.
- R6: The final sum or difference is clamped to 0x7FFF_FFFF on positive overflow and to 0x8000_0000 on negative overflow.
- R7: sat_out is high together with valid_out exactly when the doubling stage or the add/subtract stage of that operation saturated. It is low in all other cycles.
- R8: q_flag becomes 1 in the cycle after a saturating operation. It stays 1 through later non-saturating operations and idle cycles until it is cleared.
- R9: q_clear high on a clock clears q_flag in the next cycle. If a saturating operation is accepted on the same clock, q_flag ends up 1. q_clear has no effect on the result, valid_out or sat_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and op_sub are valid this cycle |
| op_sub | input | 1 | 0 selects double-and-add, 1 selects double-and-subtract |
| a | input | 32 | First signed operand |
| b | input | 32 | Second signed operand, the one that is doubled |
| q_clear | input | 1 | Synchronous clear of the sticky flag |
| result | output | 32 | Registered signed result |
| valid_out | output | 1 | Result is new this cycle |
| sat_out | output | 1 | The operation whose result is presented saturated at either stage |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The patterns are chosen so that each stage can be seen on its own:
- **Small operands** exercise plain doubling and addition or subtraction, with no clamping at either stage.
- **B near ±2^30** saturates the doubling stage alone. A = -1 together with B = 0x4000_0000 tells two-stage clamping apart from a single wide clamp.
- **A near the range limits** with modest B saturates only the final stage.
- **B = 0x8000_0000 subtracted from a non-negative A** saturates both stages.
- **Random operands, random op select, and random clear pulses interleaved with idle cycles** are compared each clock against a 64-bit integer model. These runs show the sticky flag's set-beats-clear priority and that the result holds between operations.

// File: rtl/sat_dbl_acc.sv
module sat_dbl_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic         op_sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         q_clear,
  output logic [W-1:0] result,
  output logic         valid_out,
  output logic         sat_out,
  output logic         q_flag
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic         dbl_ovf;
  logic [W-1:0] dbl;
  logic [W:0]   wide;
  logic         sum_ovf;
  logic [W-1:0] fin;
  logic         sat_now;

  assign dbl_ovf = b[W-1] ^ b[W-2];
  assign dbl     = dbl_ovf ? (b[W-1] ? MINV : MAXV) : {b[W-2:0], 1'b0};
  assign wide    = op_sub ? ({a[W-1], a} - {dbl[W-1], dbl})
                          : ({a[W-1], a} + {dbl[W-1], dbl});
  assign sum_ovf = wide[W] ^ wide[W-1];
  assign fin     = sum_ovf ? (wide[W] ? MINV : MAXV) : wide[W-1:0];
  assign sat_now = dbl_ovf | sum_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      valid_out <= 1'b0;
      sat_out   <= 1'b0;
      q_flag    <= 1'b0;
    end else begin
      valid_out <= valid_in;
      sat_out   <= valid_in & sat_now;
      if (valid_in) result <= fin;
      if (valid_in && sat_now) q_flag <= 1'b1;
      else if (q_clear)        q_flag <= 1'b0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !valid_out && !sat_out && !q_flag));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> (!valid_out && $stable(result)));

  // R7
  sat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sat_out |-> valid_out);

  // R8
  sat_sets_q_chk: assert property (@(posedge clk) disable iff (rst)
    sat_out |-> q_flag);

  // R8
  q_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !q_clear) |=> q_flag);

  // R9
  q_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (q_clear && !valid_in) |=> !q_flag);

endmodule

// File: tb/test_sat_dbl_acc.sv
`timescale 1ns/1ps
module test_sat_dbl_acc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        q_clear = 1'b0;
  logic [31:0] result;
  logic        valid_out, sat_out, q_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] e_res;
  logic        e_val, e_sat, e_q;

  always #2 clk = ~clk;

  sat_dbl_acc i_sat_dbl_acc (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op_sub(op_sub),
    .a(a), .b(b), .q_clear(q_clear),
    .result(result), .valid_out(valid_out), .sat_out(sat_out), .q_flag(q_flag)
  );

  localparam longint LMAX = 64'sd2147483647;
  localparam longint LMIN = -64'sd2147483648;

  task automatic check(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "result", result, e_res);
    check("R2", "valid_out", valid_out, e_val);
    check("R7", "sat_out", sat_out, e_sat);
    check("R8", "q_flag", q_flag, e_q);
  endtask

  task automatic step(string tag, bit vin, bit sub, logic [31:0] av,
                      logic [31:0] bv, bit qc);
    longint d, s;
    bit s1, s2;
    valid_in = vin; op_sub = sub; a = av; b = bv; q_clear = qc;
    d = 2 * longint'($signed(bv));
    s1 = (d > LMAX) || (d < LMIN);
    if (d > LMAX) d = LMAX;
    if (d < LMIN) d = LMIN;
    s = sub ? longint'($signed(av)) - d : longint'($signed(av)) + d;
    s2 = (s > LMAX) || (s < LMIN);
    if (s > LMAX) s = LMAX;
    if (s < LMIN) s = LMIN;
    e_val = vin;
    e_sat = vin && (s1 || s2);
    if (vin) e_res = s[31:0];
    if (vin && (s1 || s2)) e_q = 1'b1;
    else if (qc) e_q = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    e_res = '0; e_val = 0; e_sat = 0; e_q = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst = 1'b0;
    // R3 plain add: 10 + 2*3 = 16
    step("R3", 1, 0, 32'd10, 32'd3, 0);
    check("R3", "add value", result, 32'd16);
    // R4 plain subtract: 10 - 2*7 = -4
    step("R4", 1, 1, 32'd10, 32'd7, 0);
    check("R4", "sub value", result, 32'hFFFF_FFFC);
    // R2 idle hold
    step("R2", 0, 0, 32'd99, 32'd99, 0);
    check("R2", "hold", result, 32'hFFFF_FFFC);
    // R5 doubling clamp only: -1 + 0x7FFFFFFF
    step("R5", 1, 0, 32'hFFFF_FFFF, 32'h4000_0000, 0);
    check("R5", "two-stage", result, 32'h7FFF_FFFE);
    check("R7", "dbl sat pulse", sat_out, 1);
    // R8 sticky through non-saturating op
    step("R8", 1, 0, 32'd1, 32'd1, 0);
    check("R8", "sticky", q_flag, 1);
    // R9 clear
    step("R9", 0, 0, 0, 0, 1);
    check("R9", "cleared", q_flag, 0);
    // R6 final clamp positive
    step("R6", 1, 0, 32'h7FFF_FFF0, 32'h10, 0);
    check("R6", "pos clamp", result, 32'h7FFF_FFFF);
    // R6 final clamp negative
    step("R6", 1, 1, 32'h8000_0010, 32'h10, 0);
    check("R6", "neg clamp", result, 32'h8000_0000);
    // R5 both stages: 5 - sat(2*MIN)
    step("R5", 1, 1, 32'd5, 32'h8000_0000, 1);
    check("R5", "min double sub", result, 32'h7FFF_FFFF);
    check("R9", "set beats clear", q_flag, 1);
    // R9 clear with a non-saturating op
    step("R9", 1, 0, 32'd2, 32'd2, 1);
    check("R9", "clear with op", q_flag, 0);
    check("R9", "result unaffected", result, 32'd6);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      bit sub;
      ra = $urandom; rb = $urandom;
      if ($urandom_range(3) == 0) rb = {rb[31], rb[31], rb[29:0]} ^ 32'h0000_0001;
      if ($urandom_range(3) == 0) ra = {ra[31], {7{~ra[31]}}, ra[23:0]};
      sub = $urandom_range(1);
      step(sub ? "R4" : "R3", $urandom_range(3) != 0, sub, ra, rb,
           $urandom_range(7) == 0);
    end
    rst = 1'b1;
    e_res = '0; e_val = 0; e_sat = 0; e_q = 0;
    @(posedge clk); @(negedge clk);
    compare("R1");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule